// File: doc/BRIEF.md
# I2C Register Slave with Busy Polling

This block is the two-wire serial front end of a small register-based peripheral. It oversamples SCL and SDA on a fast system clock and finds START and STOP conditions. It receives an identification byte and checks that byte against a fixed device-type nibble and two strapped address pins. It then decodes an instruction byte and runs one command against a file of four 8-bit registers. The register contents are brought out in parallel to the logic that uses them.

A nonvolatile store command is an instruction byte, then one data byte, then a STOP. That STOP starts an internal write cycle whose length is a parameterised number of clock cycles. While the cycle runs, the slave does not acknowledge its own identification byte. A bus master can therefore send its address repeatedly and wait for the first acknowledge before it goes on. SDA is modelled as an open-drain enable: a high output pulls the line low.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset, SDA is released, all four registers read zero and no write cycle is running, so the first matching identification byte is acknowledged.
- R2: The identification byte is received MSB first. Bits 7:4 must be 4'b0101. Bits 3:2 must equal `addr_pins` (bit 3 against pin 1). Bit 1 is ignored. Bit 0 is the direction (0 write, 1 read). When all of this holds, the slave acknowledges by holding SDA low for the ninth clock.
- R3: If the identification byte does not match, the slave gives no acknowledge, acknowledges nothing more and changes no register until the next START.
- R4: In the instruction byte, bits 7:5 are the opcode and bits 1:0 select the register; bits 4:2 are ignored. Opcode 3'b100 only selects the register for reading, 3'b101 writes it and 3'b110 writes it and requests a nonvolatile store. Any other opcode is not acknowledged and the transaction is ignored.
- R5: After a write or store opcode, exactly one data byte is acknowledged and written to the selected register. Any further byte in the same transaction is not acknowledged and has no effect.
- R6: In a transaction with direction 1, the slave sends the selected register MSB first. It sends it again after each master acknowledge and stops driving after a master non-acknowledge.
- R7: A STOP that follows an acknowledged store data byte starts a busy period of WRITE_CYCLES clocks. During that period a matching identification byte is not acknowledged and the rest of its transaction is ignored. After the period ends, the identification byte is acknowledged again.
- R8: A store data byte that is followed by a repeated START instead of a STOP starts no busy period. Neither does a write opcode that is followed by a STOP.
- R9: A START or STOP in the middle of a byte abandons the transaction without writing any register. The next START is received as a fresh identification byte.
- R10: The slave changes its SDA drive only on a falling SCL edge, a START or a STOP. The acknowledge is held from the fall after bit 8 to the fall after bit 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_pins | input | 2 | Strapped address bits compared with identification bits 3:2 |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| reg_vals | output | 32 | Register contents, register n in bits 8n+7:8n |

## Verification
The bench builds the slave with WRITE_CYCLES set to 2000 and the address pins strapped to 2'b10. Each byte takes about 290 clocks, so the bench can poll while the slave is busy and again after the busy period has expired, well inside the run time. The device-type nibble, the opcode values and the two-flop synchronisers keep their defaults. All the timing the bench relies on therefore comes from a quarter SCL period of eight system clocks, which leaves a few clocks of margin over the synchroniser delay.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire register slave.
// Assumes: one bit engine per slave, bytes of eight bits.
package twi_pkg;

    // Bit engine phase.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_SKIP
    } twi_state_e;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        BK_ID,
        BK_INSTR,
        BK_DATA,
        BK_EXTRA
    } byte_kind_e;

endpackage

// File: rtl/twi_cond_detect.sv
// Line conditioner: synchronises SCL and SDA into clk and flags SCL edges,
// START (SDA falls while SCL high) and STOP (SDA rises while SCL high).
// Assumes: clk is several times faster than SCL; SYNC_STAGES >= 2.
module twi_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_lvl;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchroniser chains; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_lvl = scl_sh[SYNC_STAGES-1];
    assign sda_lvl = sda_sh[SYNC_STAGES-1];

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/twi_busy_timer.sv
// Internal write-cycle timer: an arm pulse keeps busy high for exactly
// WRITE_CYCLES clocks.
// Assumes: arm is not pulsed while busy (the bit engine refuses commands then).
module twi_busy_timer #(
    parameter int WRITE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic busy
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] remain;

    // Down-counter; reloaded by arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (arm) begin
            remain <= CW'(WRITE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/twi_regfile.sv
// Register file: N_REGS registers of DW bits with one write port, one
// combinational read port and a flat parallel view.
// Assumes: raddr and waddr are always below N_REGS (N_REGS is a power of two).
module twi_regfile #(
    parameter int N_REGS = 4,
    parameter int DW     = 8,
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [AW-1:0]      raddr,
    output logic [DW-1:0]      rdata,
    output logic [N_REGS*DW-1:0] regs_flat
);
    logic [DW-1:0] mem [N_REGS];

    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
        // Storage for one register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[gi] <= '0;
            end else if (we && waddr == AW'(gi)) begin
                mem[gi] <= wdata;
            end
        end
        assign regs_flat[gi*DW +: DW] = mem[gi];
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/twi_xfer_fsm.sv
// Byte engine: receives the identification, instruction and data bytes,
// drives acknowledge and read data, issues register writes, and requests
// the write-cycle timer when a store command is closed by STOP.
// Assumes: conditions and edges come from twi_cond_detect.
module twi_xfer_fsm
    import twi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101,
    parameter logic [2:0] OP_READ  = 3'b100,
    parameter logic [2:0] OP_WRITE = 3'b101,
    parameter logic [2:0] OP_STORE = 3'b110,
    parameter int         AW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [1:0]    addr_pins,
    input  logic          busy,
    input  logic [7:0]    rdata,
    output logic          sda_oe,
    output logic          we,
    output logic [AW-1:0] ptr,
    output logic [7:0]    wdata,
    output logic          arm,
    output twi_state_e    state
);
    byte_kind_e  kind;
    logic [3:0]  cnt;
    logic [7:0]  sr;
    logic [7:0]  tx_sr;
    logic [2:0]  op_q;
    logic        rw;
    logic        mack;
    logic        store_pend;
    logic        id_ok;
    logic        op_ok;

    assign id_ok = (sr[7:4] == DEV_TYPE) && (sr[3:2] == addr_pins) && !busy;
    assign op_ok = (sr[7:5] == OP_READ) || (sr[7:5] == OP_WRITE)
                || (sr[7:5] == OP_STORE);

    // Main sequencer: conditions first, then per-phase SCL edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= BK_ID;
            cnt        <= '0;
            sr         <= '0;
            tx_sr      <= '0;
            op_q       <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            store_pend <= 1'b0;
            ptr        <= '0;
            wdata      <= '0;
            we         <= 1'b0;
            arm        <= 1'b0;
        end else begin
            we  <= 1'b0;
            arm <= 1'b0;
            if (start_det) begin
                state      <= ST_RX;
                kind       <= BK_ID;
                cnt        <= '0;
                store_pend <= 1'b0;
            end else if (stop_det) begin
                state      <= ST_IDLE;
                arm        <= store_pend;
                store_pend <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && cnt != 4'd8) begin
                            sr  <= {sr[6:0], sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            case (kind)
                                BK_ID: begin
                                    if (id_ok) begin
                                        state <= ST_ACK;
                                        rw    <= sr[0];
                                        kind  <= BK_INSTR;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                                BK_INSTR: begin
                                    if (op_ok) begin
                                        state <= ST_ACK;
                                        op_q  <= sr[7:5];
                                        ptr   <= sr[AW-1:0];
                                        kind  <= (sr[7:5] == OP_READ) ? BK_EXTRA : BK_DATA;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end
                                BK_DATA: begin
                                    state <= ST_ACK;
                                    we    <= 1'b1;
                                    wdata <= sr;
                                    kind  <= BK_EXTRA;
                                    if (op_q == OP_STORE) begin
                                        store_pend <= 1'b1;
                                    end
                                end
                                default: state <= ST_SKIP;
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                state <= ST_TX;
                                tx_sr <= rdata;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == 4'd7) begin
                                state <= ST_TXACK;
                            end else begin
                                tx_sr <= {tx_sr[6:0], 1'b0};
                                cnt   <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (mack) begin
                                state <= ST_TX;
                                tx_sr <= rdata;
                                cnt   <= '0;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Open-drain drive: acknowledge, or a zero data bit while sending.
    assign sda_oe = (state == ST_ACK) || (state == ST_TX && !tx_sr[7]);

endmodule

// File: rtl/twi_reg_slave.sv
// Top: two-wire register slave with a timed internal write cycle during
// which its own address is not acknowledged.
// Assumes: clk much faster than SCL; no clock stretching; 7-bit addressing.
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE     = 4'b0101,
    parameter logic [2:0] OP_READ      = 3'b100,
    parameter logic [2:0] OP_WRITE     = 3'b101,
    parameter logic [2:0] OP_STORE     = 3'b110,
    parameter int         N_REGS       = 4,
    parameter int         WRITE_CYCLES = 250000,
    parameter int         SYNC_STAGES  = 2,
    localparam int        DW           = 8,
    localparam int        AW           = $clog2(N_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [1:0]           addr_pins,
    output logic                 sda_oe,
    output logic [N_REGS*DW-1:0] reg_vals
);
    logic          sda_lvl;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_det;
    logic          stop_det;
    logic          busy;
    logic          store_arm;
    logic          reg_we;
    logic [AW-1:0] reg_ptr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    twi_state_e    eng_state;

    twi_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twi_xfer_fsm #(
        .DEV_TYPE(DEV_TYPE),
        .OP_READ (OP_READ),
        .OP_WRITE(OP_WRITE),
        .OP_STORE(OP_STORE),
        .AW      (AW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .addr_pins(addr_pins),
        .busy     (busy),
        .rdata    (reg_rdata),
        .sda_oe   (sda_oe),
        .we       (reg_we),
        .ptr      (reg_ptr),
        .wdata    (reg_wdata),
        .arm      (store_arm),
        .state    (eng_state)
    );

    twi_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (store_arm),
        .busy (busy)
    );

    twi_regfile #(.N_REGS(N_REGS), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .waddr    (reg_ptr),
        .wdata    (reg_wdata),
        .raddr    (reg_ptr),
        .rdata    (reg_rdata),
        .regs_flat(reg_vals)
    );

endmodule

// File: rtl/twi_reg_slave_chk.sv
// Checker for twi_reg_slave: relates drive timing, busy window, timer
// arming and register writes. Attached by the bind at the end of the file.
module twi_reg_slave_chk
    import twi_pkg::*;
#(
    parameter int WRITE_CYCLES = 250000,
    parameter int RV_W         = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_fall,
    input logic            start_det,
    input logic            stop_det,
    input logic            sda_oe,
    input logic            busy,
    input logic            store_arm,
    input logic            reg_we,
    input logic [RV_W-1:0] reg_vals
);
    logic [31:0] busy_run;

    // Length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 32'd1;
        end else begin
            busy_run <= '0;
        end
    end

    assert_oe_on_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == 32'(WRITE_CYCLES)));

    assert_quiet_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    assert_arm_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_arm |-> $past(stop_det));

    assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe);

    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(reg_vals));

endmodule

bind twi_reg_slave twi_reg_slave_chk #(
    .WRITE_CYCLES(WRITE_CYCLES),
    .RV_W        (N_REGS*DW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .store_arm(store_arm),
    .reg_we   (reg_we),
    .reg_vals (reg_vals)
);

// File: tb/sim_twi_reg_slave.sv
// Directed bench: a bus master model drives SCL/SDA with a wired-AND line.
module sim_twi_reg_slave;
    localparam int WCYC = 2000;
    localparam int Q    = 8;
    localparam logic [7:0] IDW = 8'h58;   // 0101 10 0 0
    localparam logic [7:0] IDR = 8'h59;   // 0101 10 0 1

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [31:0] reg_vals;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_reg_slave #(.WRITE_CYCLES(WCYC)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .addr_pins(2'b10),
        .sda_oe   (sda_oe),
        .reg_vals (reg_vals)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        if (scl_m == 1'b0) begin
            wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        end else begin
            sda_m = 1'b1; wclk(Q);
        end
        sda_m = 1'b0; wclk(2*Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(Q); sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(2*Q); sda_m = 1'b1; wclk(2*Q);
    endtask

    task automatic send_bit(input logic b);
        wclk(Q); sda_m = b; wclk(Q); scl_m = 1'b1; wclk(2*Q); scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
        ack = ~sda_line;
        wclk(Q); scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            wclk(Q); sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
            d[i] = sda_line;
            wclk(Q); scl_m = 1'b0;
        end
        send_bit(~mack);
    endtask

    // Address-only poll; returns whether the slave acknowledged.
    task automatic poll(output logic ack);
        bus_start(); write_byte(IDW, ack); bus_stop();
    endtask

    task automatic t_reset();
        check("R1 sda released", {31'd0, sda_oe}, 32'd0);
        check("R1 registers zero", reg_vals, 32'd0);
    endtask

    task automatic t_write_read();
        logic a; logic [7:0] d;
        bus_start();
        write_byte(IDW, a);   check("R2 id ack", {31'd0, a}, 32'd1);
        write_byte(8'hA1, a); check("R4 write opcode ack", {31'd0, a}, 32'd1);
        write_byte(8'h3C, a); check("R5 data ack", {31'd0, a}, 32'd1);
        bus_stop();
        check("R5 reg1 written", {24'd0, reg_vals[15:8]}, 32'h3C);
        poll(a);              check("R8 write+stop not busy", {31'd0, a}, 32'd1);
        bus_start();
        write_byte(IDW, a);
        write_byte(8'h9D, a); check("R4 read opcode ack, bits 4:2 ignored", {31'd0, a}, 32'd1);
        bus_start();
        write_byte(IDR, a);   check("R6 read id ack", {31'd0, a}, 32'd1);
        read_byte(1'b1, d);   check("R6 first read byte", {24'd0, d}, 32'h3C);
        read_byte(1'b0, d);   check("R6 repeat after master ack", {24'd0, d}, 32'h3C);
        bus_stop();
        check("R6 released after nack", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic t_bad_id();
        logic a;
        bus_start();
        write_byte(8'h78, a); check("R2 wrong type nibble nack", {31'd0, a}, 32'd0);
        write_byte(8'hA0, a); check("R3 no ack after mismatch", {31'd0, a}, 32'd0);
        write_byte(8'hFF, a);
        bus_stop();
        check("R3 reg0 untouched", {24'd0, reg_vals[7:0]}, 32'h00);
        bus_start();
        write_byte(8'h54, a); check("R2 wrong pins nack", {31'd0, a}, 32'd0);
        bus_stop();
        bus_start();
        write_byte(8'h5A, a); check("R2 bit1 ignored", {31'd0, a}, 32'd1);
        bus_stop();
    endtask

    task automatic t_bad_op();
        logic a;
        bus_start();
        write_byte(IDW, a);
        write_byte(8'hE0, a); check("R4 unknown opcode nack", {31'd0, a}, 32'd0);
        write_byte(8'h44, a); check("R4 data after bad opcode nack", {31'd0, a}, 32'd0);
        bus_stop();
        check("R4 reg0 untouched", {24'd0, reg_vals[7:0]}, 32'h00);
    endtask

    task automatic t_extra_byte();
        logic a;
        bus_start();
        write_byte(IDW, a);
        write_byte(8'hA3, a);
        write_byte(8'h11, a);
        write_byte(8'h22, a); check("R5 extra byte nack", {31'd0, a}, 32'd0);
        bus_stop();
        check("R5 reg3 keeps first byte", {24'd0, reg_vals[31:24]}, 32'h11);
    endtask

    task automatic t_store();
        logic a;
        bus_start();
        write_byte(IDW, a);
        write_byte(8'hC2, a); check("R4 store opcode ack", {31'd0, a}, 32'd1);
        write_byte(8'hA5, a);
        bus_stop();
        check("R7 reg2 stored", {24'd0, reg_vals[23:16]}, 32'hA5);
        bus_start();
        write_byte(IDW, a);   check("R7 busy nack", {31'd0, a}, 32'd0);
        write_byte(8'hA2, a);
        write_byte(8'h00, a);
        bus_stop();
        check("R7 busy command ignored", {24'd0, reg_vals[23:16]}, 32'hA5);
        wclk(300);
        poll(a);              check("R7 still busy mid cycle", {31'd0, a}, 32'd0);
        wclk(WCYC);
        poll(a);              check("R7 ack after cycle", {31'd0, a}, 32'd1);
    endtask

    task automatic t_store_rs();
        logic a; logic [7:0] d;
        bus_start();
        write_byte(IDW, a);
        write_byte(8'hC0, a);
        write_byte(8'h5A, a);
        bus_start();
        write_byte(IDR, a);   check("R8 repeated start not busy", {31'd0, a}, 32'd1);
        read_byte(1'b0, d);   check("R8 stored value readable", {24'd0, d}, 32'h5A);
        bus_stop();
        poll(a);              check("R8 no busy after read stop", {31'd0, a}, 32'd1);
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        write_byte(IDW, a);
        write_byte(8'hA1, a);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        check("R9 stop mid byte no write", {24'd0, reg_vals[15:8]}, 32'h3C);
        bus_start();
        write_byte(IDW, a);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        write_byte(IDW, a);   check("R9 restart after mid byte start", {31'd0, a}, 32'd1);
        write_byte(8'hA1, a);
        write_byte(8'h77, a);
        bus_stop();
        check("R9 fresh command works", {24'd0, reg_vals[15:8]}, 32'h77);
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_write_read();
        t_bad_id();
        t_bad_op();
        t_extra_byte();
        t_store();
        t_store_rs();
        t_abort();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule